// File: doc/BRIEF.md
# Frame Resolution Learner and Output Gate

This block sits at the head of a video pipeline. It watches a pixel stream that has a per-cycle valid flag and a one-cycle end-of-frame strobe. It learns the picture size from the stream itself and needs no configuration. While the first frame after reset is passing, it measures the length of the first run of valid samples, which gives the line width. It also counts how many runs end, which gives the number of lines. When the first end-of-frame strobe arrives, it freezes both values and raises an enable that lets the processing stages downstream emit pixels.

The first end-of-frame strobe only closes the learning phase and is not passed on. Every later strobe is forwarded to the output side after a fixed delay, so that it stays aligned with the processing pipeline that the enable gates.

Reset input is active low and acts asynchronously. Its release reaches the internal registers through a short synchronizer.

Top module: `frame_res_gate`

## Requirements
- R1: While reset is asserted, and from reset release until the first end-of-frame strobe, `out_en_o` is 0, `width_o` is 0, `height_o` is 0 and `frame_end_o` is 0.
- R2: `width_o` becomes the length, in valid cycles, of the first run of consecutive high `pix_vld_i` cycles that is ended by a low `pix_vld_i` cycle. Later runs in the first frame, whether longer or shorter, do not change it.
- R3: `height_o` becomes the number of high-to-low transitions of `pix_vld_i` seen before the first end-of-frame strobe. A transition that falls in the same cycle as that strobe is counted.
- R4: `width_o`, `height_o` and `out_en_o` take their new values on the clock edge that samples the first high `frame_end_i`. Before that edge `out_en_o` is 0, and after it `out_en_o` stays 1 until reset.
- R5: The first high `frame_end_i` after reset never produces a pulse on `frame_end_o`.
- R6: Every high `frame_end_i` cycle sampled while `out_en_o` is 1 produces exactly one high `frame_end_o` cycle, EOF_LAT clock edges after the sampling edge (edge count including the sampling edge). Back-to-back strobes give back-to-back pulses.
- R7: Once `out_en_o` is 1, `width_o` and `height_o` do not change, whatever line lengths or line counts later frames have.
- R8: Idle cycles that have no valid cycle before them do not count as lines, and a gap of several idle cycles counts as one line end. A first frame with no valid cycles gives width 0 and height 0, and `out_en_o` is still set.
- R9: A valid run longer than 2^PIX_W-1 cycles measures as 2^PIX_W-1. The measurement saturates and does not wrap.
- R10: Driving `rst_ni` low clears all outputs at once, with no clock edge. After `rst_ni` rises, the registers leave reset on the SYNC_STAGES-th clock edge, and samples at earlier edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pix_vld_i | input | 1 | High in cycles that carry a pixel sample |
| frame_end_i | input | 1 | One-cycle end-of-frame strobe |
| width_o | output | PIX_W | Learned pixels per line, 0 until learned |
| height_o | output | LINE_W | Learned lines per frame, 0 until learned |
| out_en_o | output | 1 | High once the resolution is known |
| frame_end_o | output | 1 | Delayed end-of-frame strobe, first one removed |

## Verification
The assertions take the synchronized internal reset as their disable condition. They assume that any end-of-frame strobe they see comes after that reset has released, so that the first strobe always closes learning. The bench keeps to this: after every reset it waits more than SYNC_STAGES idle cycles before it drives a frame. The only exception is the reset-release scenario, and there it drives valid samples but no strobe until the synchronizer has released. The bench changes inputs only on falling clock edges. It always keeps `pix_vld_i` low in a strobe cycle, because a line must already have ended by then.

// File: rtl/frg_pkg.sv
package frg_pkg;
  typedef enum logic {
    PH_LEARN = 1'b0,
    PH_RUN   = 1'b1
  } phase_t;
endpackage

// File: rtl/frg_rst_sync.sv
module frg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/frg_run_meter.sv
module frg_run_meter #(
  parameter int PIX_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pix_vld_i,
  output logic             line_end_o,
  output logic [PIX_W-1:0] run_len_o,
  output logic [PIX_W-1:0] first_len_o,
  output logic             first_seen_o
);
  localparam logic [PIX_W-1:0] RUN_MAX = {PIX_W{1'b1}};

  logic             prev_vld_q, prev_vld_d;
  logic [PIX_W-1:0] run_q, run_d;
  logic [PIX_W-1:0] first_q, first_d;
  logic             seen_q, seen_d;
  logic             line_end;

  assign line_end = prev_vld_q & ~pix_vld_i;

  always_comb begin
    prev_vld_d = prev_vld_q;
    run_d      = run_q;
    first_d    = first_q;
    seen_d     = seen_q;
    if (en_i) begin
      prev_vld_d = pix_vld_i;
      if (pix_vld_i) begin
        run_d = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
      end else begin
        run_d = '0;
      end
      if (line_end && !seen_q) begin
        first_d = run_q;
        seen_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_vld_q <= 1'b0;
      run_q      <= '0;
      first_q    <= '0;
      seen_q     <= 1'b0;
    end else begin
      prev_vld_q <= prev_vld_d;
      run_q      <= run_d;
      first_q    <= first_d;
      seen_q     <= seen_d;
    end
  end

  assign line_end_o   = line_end & en_i;
  assign run_len_o    = run_q;
  assign first_len_o  = first_q;
  assign first_seen_o = seen_q;
endmodule

// File: rtl/frg_learn.sv
module frg_learn
  import frg_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_end_i,
  input  logic              line_end_i,
  input  logic [PIX_W-1:0]  run_len_i,
  input  logic [PIX_W-1:0]  first_len_i,
  input  logic              first_seen_i,
  output logic              learning_o,
  output logic [PIX_W-1:0]  width_o,
  output logic [LINE_W-1:0] height_o,
  output logic              out_en_o
);
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  phase_t            phase_q, phase_d;
  logic [LINE_W-1:0] lines_q, lines_d;
  logic [LINE_W-1:0] lines_inc;
  logic [PIX_W-1:0]  width_q, width_d;
  logic [LINE_W-1:0] height_q, height_d;
  logic              learning;

  assign learning  = (phase_q == PH_LEARN);
  assign lines_inc = (line_end_i && lines_q != LINE_MAX) ? lines_q + 1'b1 : lines_q;

  always_comb begin
    phase_d  = phase_q;
    lines_d  = lines_q;
    width_d  = width_q;
    height_d = height_q;
    if (learning) begin
      lines_d = lines_inc;
      if (frame_end_i) begin
        phase_d  = PH_RUN;
        height_d = lines_inc;
        if (first_seen_i)    width_d = first_len_i;
        else if (line_end_i) width_d = run_len_i;
        else                 width_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_LEARN;
      lines_q  <= '0;
      width_q  <= '0;
      height_q <= '0;
    end else begin
      phase_q  <= phase_d;
      lines_q  <= lines_d;
      width_q  <= width_d;
      height_q <= height_d;
    end
  end

  assign learning_o = learning;
  assign width_o    = width_q;
  assign height_o   = height_q;
  assign out_en_o   = ~learning;
endmodule

// File: rtl/frg_eof_pipe.sv
module frg_eof_pipe #(
  parameter int DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_end_i,
  input  logic pass_i,
  output logic frame_end_o
);
  logic [DEPTH-1:0] pipe_q;
  logic [DEPTH-1:0] pipe_d;
  logic             gated;

  assign gated = frame_end_i & pass_i;

  generate
    if (DEPTH == 1) begin : g_single
      assign pipe_d = gated;
    end else begin : g_shift
      assign pipe_d = {pipe_q[DEPTH-2:0], gated};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign frame_end_o = pipe_q[DEPTH-1];
endmodule

// File: rtl/frame_res_gate.sv
module frame_res_gate #(
  parameter int PIX_W       = 12,
  parameter int LINE_W      = 12,
  parameter int EOF_LAT     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_vld_i,
  input  logic              frame_end_i,
  output logic [PIX_W-1:0]  width_o,
  output logic [LINE_W-1:0] height_o,
  output logic              out_en_o,
  output logic              frame_end_o
);
  logic             rst_sync_n;
  logic             learning;
  logic             line_end;
  logic [PIX_W-1:0] run_len;
  logic [PIX_W-1:0] first_len;
  logic             first_seen;

  frg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_sync_n)
  );

  frg_run_meter #(.PIX_W(PIX_W)) u_meter (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .en_i         (learning),
    .pix_vld_i    (pix_vld_i),
    .line_end_o   (line_end),
    .run_len_o    (run_len),
    .first_len_o  (first_len),
    .first_seen_o (first_seen)
  );

  frg_learn #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_learn (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .frame_end_i  (frame_end_i),
    .line_end_i   (line_end),
    .run_len_i    (run_len),
    .first_len_i  (first_len),
    .first_seen_i (first_seen),
    .learning_o   (learning),
    .width_o      (width_o),
    .height_o     (height_o),
    .out_en_o     (out_en_o)
  );

  frg_eof_pipe #(.DEPTH(EOF_LAT)) u_eof (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .frame_end_i (frame_end_i),
    .pass_i      (~learning),
    .frame_end_o (frame_end_o)
  );
endmodule

// File: rtl/frame_res_gate_chk.sv
module frame_res_gate_chk #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 12
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              frame_end_i,
  input logic [PIX_W-1:0]  width_o,
  input logic [LINE_W-1:0] height_o,
  input logic              out_en_o,
  input logic              frame_end_o
);
  AST_DIMS_ZERO_UNLEARNED: assert property (@(posedge clk_i) disable iff (!rst_n)
    !out_en_o |-> (width_o == '0 && height_o == '0)); // R1
  AST_EN_RISE_ON_EOF: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(out_en_o) |-> $past(frame_end_i)); // R4
  AST_EOF_ENABLES: assert property (@(posedge clk_i) disable iff (!rst_n)
    frame_end_i |=> out_en_o); // R4
  AST_EN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    out_en_o |=> out_en_o); // R4
  AST_NO_EOF_OUT_UNLEARNED: assert property (@(posedge clk_i) disable iff (!rst_n)
    frame_end_o |-> out_en_o); // R5
  AST_DIMS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_n)
    out_en_o |=> ($stable(width_o) && $stable(height_o))); // R7
endmodule

bind frame_res_gate frame_res_gate_chk #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_sync_n),
  .frame_end_i (frame_end_i),
  .width_o     (width_o),
  .height_o    (height_o),
  .out_en_o    (out_en_o),
  .frame_end_o (frame_end_o)
);

// File: tb/frame_res_gate_tb.sv
module frame_res_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W      = 12;
  localparam int LINE_W     = 12;
  localparam int EOF_LAT    = 2;
  localparam int SYNC       = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_vld = 1'b0;
  logic frame_end_in = 1'b0;
  logic [PIX_W-1:0]  width;
  logic [LINE_W-1:0] height;
  logic out_en;
  logic frame_end_out;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_res_gate #(.PIX_W(PIX_W), .LINE_W(LINE_W), .EOF_LAT(EOF_LAT), .SYNC_STAGES(SYNC)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pix_vld_i   (pix_vld),
    .frame_end_i (frame_end_in),
    .width_o     (width),
    .height_o    (height),
    .out_en_o    (out_en),
    .frame_end_o (frame_end_out)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic e);
    @(negedge clk);
    pix_vld = v;
    frame_end_in = e;
  endtask

  task automatic line(input int w, input int gap);
    for (int i = 0; i < w; i++) step(1'b1, 1'b0);
    for (int i = 0; i < gap; i++) step(1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pix_vld = 1'b0;
    frame_end_in = 1'b0;
    repeat (3) step(1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (SYNC + 2) step(1'b0, 1'b0);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1", "out_en after reset", int'(out_en), 0);
    chk("R1", "width after reset", int'(width), 0);
    chk("R1", "height after reset", int'(height), 0);
    chk("R1", "frame_end_out after reset", int'(frame_end_out), 0);
  endtask

  task automatic t_basic_learn();
    int pulses;
    for (int l = 0; l < 4; l++) line(6, 3);
    chk("R4", "out_en before first eof", int'(out_en), 0);
    chk("R1", "width before first eof", int'(width), 0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    chk("R4", "out_en after first eof", int'(out_en), 1);
    chk("R2", "width basic", int'(width), 6);
    chk("R3", "height basic", int'(height), 4);
    pulses = (frame_end_out === 1'b1) ? 1 : 0;
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b0);
      if (frame_end_out === 1'b1) pulses++;
    end
    chk("R5", "pulses from first eof", pulses, 0);
  endtask

  task automatic t_later_frames();
    int pulses;
    for (int l = 0; l < 8; l++) line(3, 2);
    step(1'b0, 1'b1);
    for (int i = 1; i <= 4; i++) begin
      step(1'b0, 1'b0);
      chk("R6", $sformatf("frame_end_out %0d edges after eof", i), int'(frame_end_out),
          (i == EOF_LAT) ? 1 : 0);
    end
    chk("R7", "width frozen", int'(width), 6);
    chk("R7", "height frozen", int'(height), 4);
    chk("R4", "out_en stays high", int'(out_en), 1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    pulses = 0;
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 1'b0);
      if (frame_end_out === 1'b1) pulses++;
    end
    chk("R6", "back-to-back eof pulses", pulses, 2);
  endtask

  task automatic t_first_run_wins();
    do_reset();
    line(5, 1);
    line(9, 4);
    line(2, 1);
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    chk("R2", "width from first run only", int'(width), 5);
    chk("R3", "height with line end on eof cycle", int'(height), 4);
  endtask

  task automatic t_empty_frame();
    int pulses;
    do_reset();
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    chk("R8", "out_en after empty frame", int'(out_en), 1);
    chk("R8", "width after empty frame", int'(width), 0);
    chk("R8", "height after empty frame", int'(height), 0);
    step(1'b0, 1'b1);
    pulses = 0;
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b0);
      if (frame_end_out === 1'b1) pulses++;
    end
    chk("R6", "second eof forwarded once", pulses, 1);
  endtask

  task automatic t_saturate();
    do_reset();
    line(4100, 2);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    chk("R9", "width saturates", int'(width), 4095);
    chk("R9", "height with long line", int'(height), 1);
  endtask

  task automatic t_async_reset();
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    chk("R10", "out_en cleared without clock", int'(out_en), 0);
    chk("R10", "width cleared without clock", int'(width), 0);
    chk("R10", "height cleared without clock", int'(height), 0);
    repeat (2) step(1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    pix_vld = 1'b1;
    frame_end_in = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    chk("R10", "samples before sync release ignored", int'(width), 5 - SYNC);
    chk("R10", "height after release", int'(height), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset_state();
    t_basic_learn();
    t_later_frames();
    t_first_run_wins();
    t_empty_frame();
    t_saturate();
    t_async_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule